// File: doc/BRIEF.md
# Device Configuration Start-Up Sequencer

This block steps a programmable device from the moment its supplies are good, through memory initialization and loading of the configuration data, and into normal operation. It drives the chip-wide controls that hold every pad storage element low (set/reset), keep every pad driver in high impedance (three-state) and stop RAM and registers from changing (write hold). It releases them in a fixed order: set/reset first, then three-state, then write hold after a programmable delay.

The mode-select pins are captured once, at the moment memory initialization finishes. That same moment raises an init-done flag. A strap input, active low, chooses whether user pins get weak pull-ups while configuration runs. The strap counts as high when nothing drives it. Once the device is in user mode, each used pin follows its own user pull-up setting. Each unused pin takes a termination chosen by a select input: pull-down, pull-up or float.

Supply detection, memory clearing and the configuration data path are outside the block. Each is modelled as a single handshake input.

Top module: `cfg_startup_seq`

## Requirements
- R1: While pwrGood is low, and asynchronously as soon as it falls, the block reports seqState 0 with globalSetReset, globalTristate and writeHold all high and initDoneFlag low.
- R2: The states are coded on seqState as POWERUP=0, INIT=1, CONFIG=2, STARTUP=3 and USER=4. The first clock edge with pwrGood high moves POWERUP to INIT.
- R3: At the clock edge where memInitDone is high in INIT, the state becomes CONFIG, initDoneFlag goes high, and modeLatched takes the modeSel value present at that edge.
- R4: globalSetReset is high in POWERUP, INIT and CONFIG and low from STARTUP onwards, so it is always released before three-state.
- R5: At the edge where loadDone is high in CONFIG, the state becomes STARTUP. STARTUP lasts exactly one cycle and is followed by USER. globalTristate is high in every state except USER.
- R6: writeHold falls exactly WE_DELAY clock edges after the edge where globalTristate falls (default 1, parameter at least 1).
- R7: Before USER, a strap driven low (strapDriven=1, strapLevel=0) sets every weakPullUp bit. A strap driven high clears them all. weakPullDown stays zero.
- R8: An undriven strap (strapDriven=0) reads as high, so no pull-ups are enabled whatever strapLevel carries.
- R9: In USER, a used pin (its unusedMask bit is 0) shows its userPull bit on weakPullUp and 0 on weakPullDown, and the strap inputs are ignored.
- R10: In USER, an unused pin (its unusedMask bit is 1) is terminated by termSel. 2'b01 gives a pull-up, 2'b10 leaves the pin floating (both enables 0), and 2'b00 or 2'b11 give a pull-down.
- R11: After the latch, changes on modeSel do not alter modeLatched until the next power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| pwrGood | input | 1 | Supplies good; low resets the sequencer asynchronously |
| memInitDone | input | 1 | Configuration memory initialization finished |
| loadDone | input | 1 | Configuration data fully loaded |
| modeSel | input | MODE_W | Configuration mode-select pins |
| strapLevel | input | 1 | Level on the pull-up strap pin (active low) |
| strapDriven | input | 1 | Strap pin is driven externally; if 0 it reads high |
| userPull | input | NPINS | Per-pin user pull-up settings for user mode |
| unusedMask | input | NPINS | Marks pins that the design does not use |
| termSel | input | 2 | Termination for unused pins in user mode |
| seqState | output | 3 | Current sequencer state code |
| globalSetReset | output | 1 | Holds pad storage elements low |
| globalTristate | output | 1 | Holds all pad drivers in high impedance |
| writeHold | output | 1 | Blocks RAM and register writes |
| initDoneFlag | output | 1 | Memory initialization completed |
| modeLatched | output | MODE_W | Mode value captured at init completion |
| weakPullUp | output | NPINS | Per-pin weak pull-up enables |
| weakPullDown | output | NPINS | Per-pin weak pull-down enables |

## Verification
State changes, the mode capture and the init-done flag are due one clock edge after the handshake input that causes them. The bench drives each input on a falling edge and reads the result at the next falling edge. Write hold is measured by counting edges from the three-state release: one instance uses the default delay of 1 and a second uses a delay of 3. Pull enables follow the state and the pin inputs with no register in between, so the table walk reads them a short settle time after it drives the inputs. The power-loss reset is read a fraction of a cycle after pwrGood falls, with no clock edge in between.

// File: rtl/startup_pkg.sv
package startup_pkg;

  typedef enum logic [2:0] {
    ST_POWERUP = 3'd0,
    ST_INIT    = 3'd1,
    ST_CONFIG  = 3'd2,
    ST_STARTUP = 3'd3,
    ST_USER    = 3'd4
  } seqState_t;

  typedef struct packed {
    logic latchMode;
    logic userMode;
  } seqStrobe_t;

  localparam logic [1:0] TERM_PULLDOWN = 2'b00;
  localparam logic [1:0] TERM_PULLUP   = 2'b01;
  localparam logic [1:0] TERM_FLOAT    = 2'b10;

endpackage

// File: rtl/startup_ctrl.sv
module startup_ctrl
  import startup_pkg::*;
(
  input  logic       clk,
  input  logic       pwrGood,
  input  logic       memInitDone,
  input  logic       loadDone,
  output seqState_t  state,
  output seqStrobe_t strobe,
  output logic       gsrOut,
  output logic       gtsOut
);

  seqState_t nextState;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) state <= ST_POWERUP;
    else          state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_POWERUP: nextState = ST_INIT;
      ST_INIT:    if (memInitDone) nextState = ST_CONFIG;
      ST_CONFIG:  if (loadDone)    nextState = ST_STARTUP;
      ST_STARTUP: nextState = ST_USER;
      ST_USER:    nextState = ST_USER;
      default:    nextState = ST_POWERUP;
    endcase
  end

  always_comb begin
    strobe.latchMode = (state == ST_INIT) && memInitDone;
    strobe.userMode  = (state == ST_USER);
  end

  // Set/reset is held through configuration, three-state until user mode.
  assign gsrOut = (state == ST_POWERUP) || (state == ST_INIT) || (state == ST_CONFIG);
  assign gtsOut = (state != ST_USER);

endmodule

// File: rtl/startup_dp.sv
module startup_dp
  import startup_pkg::*;
#(
  parameter int NPINS    = 8,
  parameter int MODE_W   = 3,
  parameter int WE_DELAY = 1
)(
  input  logic              clk,
  input  logic              pwrGood,
  input  seqStrobe_t        strobe,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              strapLevel,
  input  logic              strapDriven,
  input  logic [NPINS-1:0]  userPull,
  input  logic [NPINS-1:0]  unusedMask,
  input  logic [1:0]        termSel,
  output logic              initDoneFlag,
  output logic [MODE_W-1:0] modeLatched,
  output logic              writeHold,
  output logic [NPINS-1:0]  weakPullUp,
  output logic [NPINS-1:0]  weakPullDown
);

  localparam int CNT_W = (WE_DELAY < 1) ? 1 : $clog2(WE_DELAY + 1);
  localparam logic [CNT_W-1:0] DELAY_LOAD = CNT_W'(WE_DELAY);

  logic [CNT_W-1:0] holdCnt;
  logic             strapPullEn;

  // Mode capture and init-done flag.
  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      modeLatched  <= '0;
      initDoneFlag <= 1'b0;
    end else if (strobe.latchMode) begin
      modeLatched  <= modeSel;
      initDoneFlag <= 1'b1;
    end
  end

  // Write-hold countdown, armed until user mode begins.
  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood)              holdCnt <= DELAY_LOAD;
    else if (!strobe.userMode) holdCnt <= DELAY_LOAD;
    else if (holdCnt != '0)    holdCnt <= holdCnt - 1'b1;
  end

  assign writeHold = !strobe.userMode || (holdCnt != '0);

  // An undriven strap reads high, which disables the pull-ups.
  assign strapPullEn = strapDriven && !strapLevel;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic pinUp, pinDn;
    always_comb begin
      pinUp = 1'b0;
      pinDn = 1'b0;
      if (!strobe.userMode) begin
        pinUp = strapPullEn;
      end else if (unusedMask[p]) begin
        unique case (termSel)
          TERM_PULLUP: pinUp = 1'b1;
          TERM_FLOAT:  pinUp = 1'b0;
          default:     pinDn = 1'b1;
        endcase
      end else begin
        pinUp = userPull[p];
      end
    end
    assign weakPullUp[p]   = pinUp;
    assign weakPullDown[p] = pinDn;
  end

endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
  import startup_pkg::*;
#(
  parameter int NPINS    = 8,
  parameter int MODE_W   = 3,
  parameter int WE_DELAY = 1
)(
  input  logic              clk,
  input  logic              pwrGood,
  input  logic              memInitDone,
  input  logic              loadDone,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              strapLevel,
  input  logic              strapDriven,
  input  logic [NPINS-1:0]  userPull,
  input  logic [NPINS-1:0]  unusedMask,
  input  logic [1:0]        termSel,
  output logic [2:0]        seqState,
  output logic              globalSetReset,
  output logic              globalTristate,
  output logic              writeHold,
  output logic              initDoneFlag,
  output logic [MODE_W-1:0] modeLatched,
  output logic [NPINS-1:0]  weakPullUp,
  output logic [NPINS-1:0]  weakPullDown
);

  seqState_t  state;
  seqStrobe_t strobe;

  startup_ctrl ctrl_i (
    .clk         (clk),
    .pwrGood     (pwrGood),
    .memInitDone (memInitDone),
    .loadDone    (loadDone),
    .state       (state),
    .strobe      (strobe),
    .gsrOut      (globalSetReset),
    .gtsOut      (globalTristate)
  );

  startup_dp #(
    .NPINS    (NPINS),
    .MODE_W   (MODE_W),
    .WE_DELAY (WE_DELAY)
  ) dp_i (
    .clk          (clk),
    .pwrGood      (pwrGood),
    .strobe       (strobe),
    .modeSel      (modeSel),
    .strapLevel   (strapLevel),
    .strapDriven  (strapDriven),
    .userPull     (userPull),
    .unusedMask   (unusedMask),
    .termSel      (termSel),
    .initDoneFlag (initDoneFlag),
    .modeLatched  (modeLatched),
    .writeHold    (writeHold),
    .weakPullUp   (weakPullUp),
    .weakPullDown (weakPullDown)
  );

  assign seqState = state;

endmodule

// File: rtl/cfg_startup_seq_chk.sv
module cfg_startup_seq_chk #(
  parameter int NPINS    = 8,
  parameter int MODE_W   = 3,
  parameter int WE_DELAY = 1
)(
  input logic              clk,
  input logic              pwrGood,
  input logic [MODE_W-1:0] modeSel,
  input logic [2:0]        seqState,
  input logic              globalSetReset,
  input logic              globalTristate,
  input logic              writeHold,
  input logic              initDoneFlag,
  input logic [MODE_W-1:0] modeLatched,
  input logic [NPINS-1:0]  weakPullUp,
  input logic [NPINS-1:0]  weakPullDown
);

  // Edges seen since the three-state release, saturating past the delay.
  int relCnt;
  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood)                relCnt <= 0;
    else if (globalTristate)     relCnt <= 0;
    else if (relCnt <= WE_DELAY) relCnt <= relCnt + 1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !pwrGood |-> (globalSetReset && globalTristate && writeHold && !initDoneFlag));

  assert_mode_capture_R3: assert property (@(posedge clk) disable iff (!pwrGood)
    $rose(initDoneFlag) |-> (modeLatched == $past(modeSel)));

  assert_gsr_first_R4: assert property (@(posedge clk) disable iff (!pwrGood)
    !globalTristate |-> (!globalSetReset && initDoneFlag));

  assert_startup_single_R5: assert property (@(posedge clk) disable iff (!pwrGood)
    (seqState == 3'd3) |=> (seqState == 3'd4));

  assert_hold_kept_R6: assert property (@(posedge clk) disable iff (!pwrGood)
    (!globalTristate && relCnt < WE_DELAY) |-> writeHold);

  assert_hold_freed_R6: assert property (@(posedge clk) disable iff (!pwrGood)
    (!globalTristate && relCnt >= WE_DELAY) |-> !writeHold);

  assert_no_pulldown_R7: assert property (@(posedge clk) disable iff (!pwrGood)
    globalTristate |-> (weakPullDown == '0));

  assert_pull_exclusive_R10: assert property (@(posedge clk) disable iff (!pwrGood)
    (weakPullUp & weakPullDown) == '0);

  assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!pwrGood)
    (initDoneFlag && $past(initDoneFlag)) |-> $stable(modeLatched));

endmodule

bind cfg_startup_seq cfg_startup_seq_chk #(
  .NPINS    (NPINS),
  .MODE_W   (MODE_W),
  .WE_DELAY (WE_DELAY)
) chk_i (.*);

// File: tb/cfg_startup_seq_tb_top.sv
module cfg_startup_seq_tb_top;

  localparam int NP = 4;
  localparam int MW = 3;

  logic          clk = 1'b0;
  logic          pwrGood, memInitDone, loadDone, strapLevel, strapDriven;
  logic [MW-1:0] modeSel;
  logic [NP-1:0] userPull, unusedMask;
  logic [1:0]    termSel;

  logic [2:0]    seqState, seqState3;
  logic          gsr, gts, hold, initDone, gsr3, gts3, hold3, initDone3;
  logic [MW-1:0] modeLat, modeLat3;
  logic [NP-1:0] pu, pd, pu3, pd3;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  cfg_startup_seq #(.NPINS(NP), .MODE_W(MW), .WE_DELAY(1)) dut_i (
    .clk(clk), .pwrGood(pwrGood), .memInitDone(memInitDone), .loadDone(loadDone),
    .modeSel(modeSel), .strapLevel(strapLevel), .strapDriven(strapDriven),
    .userPull(userPull), .unusedMask(unusedMask), .termSel(termSel),
    .seqState(seqState), .globalSetReset(gsr), .globalTristate(gts), .writeHold(hold),
    .initDoneFlag(initDone), .modeLatched(modeLat), .weakPullUp(pu), .weakPullDown(pd));

  cfg_startup_seq #(.NPINS(NP), .MODE_W(MW), .WE_DELAY(3)) dut3_i (
    .clk(clk), .pwrGood(pwrGood), .memInitDone(memInitDone), .loadDone(loadDone),
    .modeSel(modeSel), .strapLevel(strapLevel), .strapDriven(strapDriven),
    .userPull(userPull), .unusedMask(unusedMask), .termSel(termSel),
    .seqState(seqState3), .globalSetReset(gsr3), .globalTristate(gts3), .writeHold(hold3),
    .initDoneFlag(initDone3), .modeLatched(modeLat3), .weakPullUp(pu3), .weakPullDown(pd3));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Vector: termSel, unusedMask, userPull, expected pull-up, expected pull-down
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {2'b00, 4'b1100, 4'b0011, 4'b0011, 4'b1100},
    {2'b01, 4'b1010, 4'b0101, 4'b1111, 4'b0000},
    {2'b10, 4'b0110, 4'b1001, 4'b1001, 4'b0000},
    {2'b11, 4'b0001, 4'b1110, 4'b1110, 4'b0001},
    {2'b00, 4'b0000, 4'b1010, 4'b1010, 4'b0000},
    {2'b01, 4'b1111, 4'b0000, 4'b1111, 4'b0000}
  };

  initial begin
    int gapOne, gapThree;
    pwrGood = 1'b0; memInitDone = 1'b0; loadDone = 1'b0;
    modeSel = '0; strapLevel = 1'b1; strapDriven = 1'b1;
    userPull = '0; unusedMask = '0; termSel = 2'b00;

    repeat (3) @(negedge clk);
    check("R1 state", seqState, 0);
    check("R1 gsr/gts/hold", {gsr, gts, hold}, 3'b111);
    check("R1 initDone", initDone, 0);

    pwrGood = 1'b1;
    @(negedge clk);
    check("R2 INIT code", seqState, 1);
    check("R4 gsr in INIT", gsr, 1);
    @(negedge clk);
    check("R3 waits in INIT", {seqState, initDone}, {3'd1, 1'b0});

    modeSel = 3'b101; memInitDone = 1'b1;
    @(negedge clk);
    memInitDone = 1'b0;
    check("R3 CONFIG code", seqState, 2);
    check("R3 initDone", initDone, 1);
    check("R3 mode latched", modeLat, 3'b101);

    modeSel = 3'b010;
    repeat (2) @(negedge clk);
    check("R11 mode held", modeLat, 3'b101);
    check("R4 gsr in CONFIG", {gsr, gts}, 2'b11);

    strapDriven = 1'b1; strapLevel = 1'b0; #1;
    check("R7 strap low pullups", {pu, pd}, {4'b1111, 4'b0000});
    strapLevel = 1'b1; #1;
    check("R7 strap high no pullups", {pu, pd}, 8'h00);
    strapDriven = 1'b0; strapLevel = 1'b0; #1;
    check("R8 floating strap", {pu, pd}, 8'h00);
    strapDriven = 1'b1;

    @(negedge clk);
    loadDone = 1'b1;
    @(negedge clk);
    loadDone = 1'b0;
    check("R5 STARTUP code", seqState, 3);
    check("R4 gsr released", gsr, 0);
    check("R5 gts held in STARTUP", {gts, hold}, 2'b11);

    // Count edges from the three-state release to the write-hold release.
    @(negedge clk);
    check("R5 USER code", seqState, 4);
    check("R5 gts released", gts, 0);
    gapOne = 0; gapThree = 0;
    for (int k = 1; k <= 6; k++) begin
      if (hold)  gapOne   = k;
      if (hold3) gapThree = k;
      @(negedge clk);
    end
    check("R6 delay 1", gapOne, 1);
    check("R6 delay 3", gapThree, 3);
    check("R6 hold released", {hold, hold3}, 2'b00);

    // Table walk in user mode with the strap driven low (must be ignored).
    strapLevel = 1'b0;
    for (int v = 0; v < NV; v++) begin
      termSel = VEC[v][17:16]; unusedMask = VEC[v][15:12]; userPull = VEC[v][11:8];
      #1;
      check("R9/R10 pull-up vector", pu, VEC[v][7:4]);
      check("R9/R10 pull-down vector", pd, VEC[v][3:0]);
      @(negedge clk);
    end

    // Power loss between edges.
    #1 pwrGood = 1'b0;
    #1;
    check("R1 async state", seqState, 0);
    check("R1 async controls", {gsr, gts, hold, initDone}, 4'b1110);
    check("R1 mode cleared on re-entry", modeLat, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule